// File: doc/BRIEF.md
# Weighted Round Queue Scheduler

The scheduler decides which of up to `NQ` command queues bound to a single output port sends next. Each queue carries a priority level, and the level decodes into an eight-bit round-enable mask. The scheduler steps through eight rounds in turn. In a given round, a weighted queue may send only if the bit for that round is set in its mask. The number of set bits therefore sets the queue's share of the port.

A group of strict-priority queues may sit in front of the weighted queues. The group is contiguous and starts at queue 0. Any non-empty queue in the group is served before any weighted queue, and the lowest-numbered one wins. The port may use fewer than `NQ` queues; queues beyond the configured count are never served.

The grant is combinational from the scheduler state and the current non-empty flags. A consumer takes the granted queue by pulsing `grant_ack` in the same cycle.

Top module: `wrq_sched`

## Requirements
- R1: A synchronous active-low reset sets the round to 7, clears the in-round position and clears all captured masks. While reset is held and all `q_valid` are 0, `grant` is 0. The first cycle after reset with no strict queue non-empty gives no weighted grant, so round 0 is the first round served.
- R2: Level decoding, with the level of queue i held in `q_level[4*i+3:4*i]`: 0→0x00, 1→0x01, 2→0x11, 3→0x49, 4→0x55, 5→0x57, 6→0x77, 7→0x7F, 8→0xFF, and 9 to 15→0xFF. Over any eight consecutive rounds, a lone always-valid weighted queue is granted exactly as many times as its mask has set bits.
- R3: A weighted queue (index ≥ `sp_count` and < `q_count`) is eligible in round r only when bit r of the mask captured at the start of that round is 1.
- R4: A level-0 queue is never granted. With queues 0, 1 and 2 at levels 8, 1 and 0, all always valid and always acknowledged, the 18 cycles after reset give queue 0 eight grants, queue 1 one grant and queue 2 none.
- R5: Queue i is a strict queue when i < `sp_count` and i < `q_count`. If any strict queue is non-empty, the grant goes to the lowest-numbered non-empty strict queue. Round and in-round position are left unchanged.
- R6: Within a round, weighted queues are served in ascending index order. The search starts just after the last acknowledged weighted queue, so each weighted queue is served at most once per round.
- R7: A weighted grant that is not acknowledged leaves the round and the in-round position unchanged. With unchanged inputs, the same grant is shown the next cycle. `grant_ack` in a cycle with no grant has no effect.
- R8: In a cycle with no grant, the round advances by one modulo 8 at the next clock, the in-round position clears, and the masks are captured from `q_level`.
- R9: No queue with index ≥ `q_count` is ever granted.
- R10: A change of `q_level` affects eligibility only from the next round boundary (the next cycle with no grant).
- R11: `grant` is zero or one-hot. When non-zero, `grant_idx` is the index of its set bit; when zero, `grant_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| q_valid | input | NQ | Per-queue non-empty flags |
| q_level | input | NQ*4 | Per-queue priority level, 4 bits each |
| q_count | input | $clog2(NQ+1) | Number of queues bound to the port |
| sp_count | input | $clog2(NQ+1) | Size of the strict-priority group starting at queue 0 |
| grant_ack | input | 1 | Consumer takes the current grant |
| grant | output | NQ | One-hot grant, zero when idle |
| grant_idx | output | $clog2(NQ) | Index of the granted queue |

## Verification
The assertions check on every cycle that:
- the grant index agrees with the one-hot grant;
- no queue at or beyond the queue count is granted;
- a non-empty strict queue always takes the grant;
- the round moves only in idle cycles and then by exactly one;
- an unacknowledged grant freezes the round state;
- an acknowledged weighted grant lies beyond the previous one in the round.

Only the bench's scenarios show the properties that span several cycles or depend on configuration: the decoded weights show up as grant counts over eight rounds, a level change waits for the round boundary, and the first served round after reset is round 0. Those scenarios are compared every cycle against a behavioural model.

// File: rtl/wrq_pkg.sv
// Package: shared constants and the priority-level to round-mask decode.
// Assumes eight rounds; every mask is one bit per round.
package wrq_pkg;
    localparam int ROUNDS = 8;
    localparam int LVLW   = 4;
    localparam int RW     = $clog2(ROUNDS);

    typedef logic [ROUNDS-1:0] rmask_t;

    // Spread the set bits of each level so that turns do not bunch up.
    function automatic rmask_t level_to_mask(input logic [LVLW-1:0] lv);
        rmask_t m;
        case (lv)
            4'd0:    m = 8'h00;
            4'd1:    m = 8'h01;
            4'd2:    m = 8'h11;
            4'd3:    m = 8'h49;
            4'd4:    m = 8'h55;
            4'd5:    m = 8'h57;
            4'd6:    m = 8'h77;
            4'd7:    m = 8'h7F;
            default: m = 8'hFF;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/wrq_mask_decode.sv
// Module: turns the packed per-queue levels into per-queue round masks.
// Purely combinational; assumes LVLW-bit levels packed queue 0 lowest.
module wrq_mask_decode
    import wrq_pkg::*;
#(
    parameter int NQ = 8
) (
    input  logic [NQ*LVLW-1:0]       lvl_flat,
    output rmask_t [NQ-1:0]          mask
);
    for (genvar i = 0; i < NQ; i++) begin : g_dec
        // Decode the level of queue i.
        always_comb mask[i] = level_to_mask(lvl_flat[i*LVLW +: LVLW]);
    end
endmodule

// File: rtl/wrq_lowest.sv
// Module: lowest-index request picker, one-hot and binary outputs.
// Assumes N >= 2; outputs zero when no request is set.
module wrq_lowest #(
    parameter int N  = 8,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  onehot,
    output logic [IW-1:0] idx,
    output logic          any
);
    // Scan from the top so the lowest set bit is the one kept.
    always_comb begin
        idx = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (req[k]) idx = IW'(k);
        end
        any    = |req;
        onehot = any ? (N'(1) << idx) : '0;
    end
endmodule

// File: rtl/wrq_round_ctrl.sv
// Module: holds the round number, the in-round position and the masks
// captured at the last round boundary.
// Assumes adv and take are never both set (top guarantees it).
module wrq_round_ctrl
    import wrq_pkg::*;
#(
    parameter int NQ = 8,
    localparam int IW = $clog2(NQ)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               adv,
    input  logic               take,
    input  logic [IW-1:0]      take_idx,
    input  rmask_t [NQ-1:0]    mask_new,
    output logic [RW-1:0]      round,
    output logic [IW-1:0]      ptr,
    output logic               ptr_vld,
    output rmask_t [NQ-1:0]    mask_cur
);
    logic [RW-1:0] round_nx;

    // Next round number, wrapping after the last round.
    always_comb round_nx = (round == RW'(ROUNDS - 1)) ? '0 : round + 1'b1;

    // Round, position and mask capture registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            round    <= RW'(ROUNDS - 1);
            ptr      <= '0;
            ptr_vld  <= 1'b0;
            mask_cur <= '0;
        end else if (adv) begin
            round    <= round_nx;
            ptr      <= '0;
            ptr_vld  <= 1'b0;
            mask_cur <= mask_new;
        end else if (take) begin
            ptr      <= take_idx;
            ptr_vld  <= 1'b1;
        end
    end

    // R8
    round_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (round == (($past(round) == RW'(ROUNDS - 1)) ? '0 : $past(round) + 1'b1)) && !ptr_vld);

    // R7
    hold_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !take) |=> $stable(round) && $stable(ptr_vld) && $stable(ptr));

    // R6
    ptr_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> ptr_vld && (ptr == $past(take_idx)) && $stable(round));

    // R6
    ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && ptr_vld) |-> (take_idx > ptr));
endmodule

// File: rtl/wrq_sched.sv
// Module: top of the weighted round queue scheduler.
// Strict queues (below sp_count) win first, lowest index; otherwise
// weighted queues eligible in the current round are served in ascending
// order once each. An idle cycle moves to the next round.
// Assumes the consumer acknowledges in the same cycle it sees the grant.
module wrq_sched
    import wrq_pkg::*;
#(
    parameter int NQ = 8,
    localparam int IW = $clog2(NQ),
    localparam int CW = $clog2(NQ + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NQ-1:0]      q_valid,
    input  logic [NQ*LVLW-1:0] q_level,
    input  logic [CW-1:0]      q_count,
    input  logic [CW-1:0]      sp_count,
    input  logic               grant_ack,
    output logic [NQ-1:0]      grant,
    output logic [IW-1:0]      grant_idx
);
    rmask_t [NQ-1:0] mask_new;
    rmask_t [NQ-1:0] mask_cur;
    logic [RW-1:0]   round;
    logic [IW-1:0]   ptr;
    logic            ptr_vld;
    logic [NQ-1:0]   sp_req, w_req, sp_oh, w_oh;
    logic [IW-1:0]   sp_idx, w_idx;
    logic            sp_any, w_any, gnt_any, adv, take;

    wrq_mask_decode #(.NQ(NQ)) u_dec (
        .lvl_flat (q_level),
        .mask     (mask_new)
    );

    for (genvar i = 0; i < NQ; i++) begin : g_req
        // Strict request: inside the strict group and inside the port.
        always_comb sp_req[i] = q_valid[i] && (CW'(i) < sp_count) && (CW'(i) < q_count);
        // Weighted request: enabled this round and not yet passed in it.
        always_comb w_req[i]  = q_valid[i] && (CW'(i) >= sp_count) && (CW'(i) < q_count)
                              && mask_cur[i][round] && (!ptr_vld || (IW'(i) > ptr));
    end

    wrq_lowest #(.N(NQ)) u_sp (
        .req (sp_req), .onehot (sp_oh), .idx (sp_idx), .any (sp_any)
    );

    wrq_lowest #(.N(NQ)) u_w (
        .req (w_req), .onehot (w_oh), .idx (w_idx), .any (w_any)
    );

    // Strict group takes precedence over the weighted pick.
    always_comb begin
        grant     = sp_any ? sp_oh  : w_oh;
        grant_idx = sp_any ? sp_idx : w_idx;
        gnt_any   = sp_any | w_any;
        adv       = !gnt_any;
        take      = !sp_any && w_any && grant_ack;
    end

    wrq_round_ctrl #(.NQ(NQ)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (adv),
        .take     (take),
        .take_idx (w_idx),
        .mask_new (mask_new),
        .round    (round),
        .ptr      (ptr),
        .ptr_vld  (ptr_vld),
        .mask_cur (mask_cur)
    );

    // R11
    idx_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((grant == '0) ? (grant_idx == '0) : grant[grant_idx]));

    // R9
    in_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0) |-> (CW'(grant_idx) < q_count));

    // R5
    strict_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|sp_req) |-> ((grant != '0) && (CW'(grant_idx) < sp_count) && sp_req[grant_idx]));
endmodule

// File: tb/wrq_sched_test.sv
`timescale 1ns/1ps
module wrq_sched_test;
    localparam int NQ = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  qv;
    logic [31:0] qlvl;
    logic [3:0]  qc, sc;
    logic        ack;
    logic [7:0]  grant;
    logic [2:0]  gidx;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    int m_round, m_ptr;
    int m_mask[8];
    int cnt[8];
    int bubbles;

    always #2.5 clk = ~clk;

    wrq_sched #(.NQ(NQ)) uut (
        .clk (clk), .rst_n (rst_n), .q_valid (qv), .q_level (qlvl),
        .q_count (qc), .sp_count (sc), .grant_ack (ack),
        .grant (grant), .grant_idx (gidx)
    );

    function automatic int lvl_mask(input int lv);
        case (lv)
            0: return 'h00; 1: return 'h01; 2: return 'h11; 3: return 'h49;
            4: return 'h55; 5: return 'h57; 6: return 'h77; 7: return 'h7F;
            default: return 'hFF;
        endcase
    endfunction

    function automatic int popc(input int v);
        int n = 0;
        for (int b = 0; b < 8; b++) if (v[b]) n++;
        return n;
    endfunction

    // Behavioural expectation: returns the queue to grant, or -1.
    function automatic int expect_q(output bit is_sp);
        is_sp = 0;
        for (int i = 0; i < 8; i++)
            if (qv[i] && i < sc && i < qc) begin is_sp = 1; return i; end
        for (int i = 0; i < 8; i++)
            if (qv[i] && i >= sc && i < qc && m_mask[i][m_round] && i > m_ptr) return i;
        return -1;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: inputs already driven after a falling edge.
    task automatic cyc(input string tag);
        int  e;
        bit  sp;
        #1;
        e = expect_q(sp);
        if (!rst_n) e = -1;
        check({tag, " R11 grant"}, grant, (e < 0) ? 0 : (1 << e));
        check({tag, " R11 idx"}, gidx, (e < 0) ? 0 : e);
        if (grant != 0 && ack) cnt[gidx]++;
        if (rst_n && grant == 0) bubbles++;
        if (!rst_n) begin
            m_round = 7; m_ptr = -1;
            for (int i = 0; i < 8; i++) m_mask[i] = 0;
        end else if (e < 0) begin
            m_round = (m_round + 1) % 8; m_ptr = -1;
            for (int i = 0; i < 8; i++) m_mask[i] = lvl_mask(qlvl[i*4 +: 4]);
        end else if (!sp && ack) begin
            m_ptr = e;
        end
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 0; qv = 0; qlvl = 0; qc = 0; sc = 0; ack = 0;
        repeat (3) cyc("R1 reset");
        rst_n = 1;
        for (int i = 0; i < 8; i++) cnt[i] = 0;
        bubbles = 0;
    endtask

    initial begin
        rst_n = 0; qv = 0; qlvl = 0; qc = 0; sc = 0; ack = 0;
        @(negedge clk);
        do_reset();

        // R1: first cycle after reset is idle, then round 0 is served.
        qc = 2; sc = 0; qv = 8'h03; qlvl = 32'h0000_0011; ack = 1;
        #1; check("R1 first cycle idle", grant, 0);
        cyc("R1");
        check("R1 round0 grant", grant, 1);
        repeat (6) cyc("R1");

        // R4: weights 8:1:0 over 18 cycles.
        do_reset();
        qc = 3; sc = 0; qv = 8'h07; qlvl = 32'h0000_0018; ack = 1;
        repeat (18) cyc("R4");
        check("R4 level8 count", cnt[0], 8);
        check("R4 level1 count", cnt[1], 1);
        check("R4 level0 count", cnt[2], 0);

        // R2: each level, a lone queue over eight rounds.
        for (int lv = 0; lv < 11; lv++) begin
            int l = (lv == 10) ? 15 : lv;
            do_reset();
            qc = 1; sc = 0; qv = 8'h01; qlvl = 32'(l); ack = 1;
            for (int g = 0; g < 100 && bubbles < 9; g++) cyc("R2 R3");
            check("R2 grants per 8 rounds", cnt[0], popc(lvl_mask(l)));
        end

        // R5: strict group precedence, lowest index first.
        do_reset();
        qc = 6; sc = 2; qv = 8'h3F; qlvl = 32'h0088_8888; ack = 1;
        #1; check("R5 strict lowest", gidx, 0);
        repeat (4) cyc("R5");
        qv = 8'h3E;
        #1; check("R5 next strict", gidx, 1);
        repeat (3) cyc("R5");
        qv = 8'h3C;
        repeat (12) cyc("R5 R6");

        // R7: hold without ack; ack with no grant ignored.
        ack = 0;
        repeat (5) cyc("R7 hold");
        qv = 8'h00; ack = 1;
        repeat (3) cyc("R7 idle ack");

        // R9: queues at or beyond the count.
        qc = 2; sc = 0; qv = 8'hFF;
        repeat (20) cyc("R9");

        // R10: level changes mid-round wait for the boundary.
        do_reset();
        qc = 4; sc = 0; qv = 8'h0F; qlvl = 32'h0000_1111; ack = 1;
        repeat (3) cyc("R10");
        qlvl = 32'h0000_8000;
        repeat (20) cyc("R10");
        qlvl = 32'h0000_0008;
        repeat (20) cyc("R10");

        // R3 R6 R8: random traffic against the model.
        for (int n = 0; n < 4000; n++) begin
            qv  = 8'($urandom);
            ack = ($urandom % 4) != 0;
            if (n % 37 == 0) qlvl = $urandom;
            if (n % 211 == 0) begin qc = 4'($urandom % 9); sc = 4'($urandom % 4); end
            cyc("R3 R6 R8");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #900000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule